// File: doc/BRIEF.md
# Pseudowire Connectivity Handshake Controller

This block sits beside one circuit-emulation bundle and decides when that bundle's payload may flow. When connectivity checking is switched on, the block keeps the traffic gate shut and pulses a request output. The packet path turns each pulse into an echo request. The pulses repeat on a fixed period, counted in pulses of a slow tick input, until an echo reply comes back whose echoed bundle number, label and payload size all equal the local settings. The gate then opens and the requests stop.

A loss-of-connection flag closes the gate and starts the handshake again from its first request. When connectivity checking is switched off, the gate opens one cycle after the bundle is enabled and no requests are ever made. The block does not build or parse packets. It sees only a request strobe going out and the already extracted fields of each reply coming in.

Replies arrive on a valid/ready stream. Ready is tied high, so the block never applies back-pressure. Each cycle in which valid is high delivers exactly one reply, which is consumed in that cycle. The request strobe, the traffic gate and the state code are plain level or pulse outputs with no handshake.

Top module: `pw_handshake_ctrl`

## Requirements
- R1: During and after reset, until enable rises, the state output reads IDLE (code 0), traffic_en is low and req_strobe is low.
- R2: With OAM checking on, the first request pulse appears in the cycle after enable is sampled high. The state then reads REQUESTING (code 1) and traffic_en stays low.
- R3: A reply counts as valid only when rep_valid is high and rep_bid, rep_lbl and rep_size all equal cfg_bid, cfg_lbl and cfg_size. A reply with any one of these fields different changes neither the state nor traffic_en. rep_ready is always high.
- R4: While REQUESTING, req_strobe pulses for one cycle on every PERIOD_TICKS-th tick counted from the previous request, and at no other time.
- R5: A valid reply sampled while REQUESTING makes the state CONNECTED (code 2) with traffic_en high in the next cycle. No request follows, even when the reply coincides with the period's last tick. Replies received while CONNECTED have no effect.
- R6: link_lost sampled while CONNECTED, with OAM checking on, gives REQUESTING, traffic_en low and a request pulse in the next cycle, with the period restarted. While REQUESTING, link_lost restarts the period with a fresh pulse and outranks a valid reply in the same cycle.
- R7: A mismatching reply leaves the period counter running, so the next request still lands PERIOD_TICKS ticks after the previous one.
- R8: With OAM checking off, an enabled bundle reads CONNECTED with traffic_en high one cycle after enable. It never pulses req_strobe, and link_lost has no effect on it.
- R9: Enable sampled low gives IDLE, traffic_en low and no request in the next cycle, whatever else is happening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bundle enable |
| oam_en | input | 1 | Connectivity checking on |
| tick | input | 1 | One-cycle pulse of the slow period time base |
| link_lost | input | 1 | Loss-of-connection indication |
| rep_valid | input | 1 | Echo reply present |
| rep_ready | output | 1 | Reply accepted (always high) |
| rep_bid | input | BID_W | Echoed bundle number |
| rep_lbl | input | LBL_W | Echoed label |
| rep_size | input | SZ_W | Echoed payload size |
| cfg_bid | input | BID_W | Local bundle number |
| cfg_lbl | input | LBL_W | Local label |
| cfg_size | input | SZ_W | Local payload size |
| req_strobe | output | 1 | One-cycle echo request pulse |
| traffic_en | output | 1 | Payload gate open |
| state_o | output | 2 | 0 IDLE, 1 REQUESTING, 2 CONNECTED |

## Verification
The bench sends replies that differ from the local settings in exactly one field at a time. A comparator that leaves a field out would open the gate early. Between those bad replies, the bench keeps counting ticks. A design that reset its timer on any reply would emit its next request late, and the scoreboard would see it in the wrong cycle.

Two coincidences are driven on purpose. In the first, a good reply lands on the period's final tick; a design that lets the timer win would leak one extra request after connecting. In the second, link_lost meets a good reply; a design that lets the reply win would open the gate on a broken link. The bench also toggles OAM checking and the enable to catch a gate that waits for a handshake it should skip, and a design that keeps requesting after being disabled.

// File: rtl/pw_hs_pkg.sv
package pw_hs_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_REQ  = 2'd1,
    PW_CONN = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_reply_match.sv
module pw_reply_match #(
  parameter int BID_W = 8,
  parameter int LBL_W = 20,
  parameter int SZ_W  = 12
) (
  input  logic             rep_valid,
  input  logic [BID_W-1:0] rep_bid,
  input  logic [LBL_W-1:0] rep_lbl,
  input  logic [SZ_W-1:0]  rep_size,
  input  logic [BID_W-1:0] cfg_bid,
  input  logic [LBL_W-1:0] cfg_lbl,
  input  logic [SZ_W-1:0]  cfg_size,
  output logic             hit
);
  localparam int NFLD = 3;
  localparam int TOT_W = BID_W + LBL_W + SZ_W;
  localparam int OFF1 = BID_W;
  localparam int OFF2 = BID_W + LBL_W;

  logic [TOT_W-1:0] rep_all, cfg_all;
  logic [NFLD-1:0]  fld_eq;

  assign rep_all = {rep_size, rep_lbl, rep_bid};
  assign cfg_all = {cfg_size, cfg_lbl, cfg_bid};

  // One comparator per echoed field; all must agree for a hit.
  generate
    for (genvar f = 0; f < NFLD; f++) begin : g_fld
      localparam int LO = (f == 0) ? 0 : ((f == 1) ? OFF1 : OFF2);
      localparam int HI = (f == 0) ? OFF1 - 1 : ((f == 1) ? OFF2 - 1 : TOT_W - 1);
      assign fld_eq[f] = (rep_all[HI:LO] == cfg_all[HI:LO]);
    end
  endgenerate

  assign hit = rep_valid && (&fld_eq);
endmodule

// File: rtl/pw_req_timer.sv
module pw_req_timer #(
  parameter int PERIOD_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic req_strobe
);
  localparam int CNT_W = $clog2(PERIOD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (restart) begin
        cnt_q    <= '0;
        strobe_q <= 1'b1;
      end else if (run && tick) begin
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_strobe = strobe_q;

  // R4: a request only follows a restart or a counted tick
  a_r4_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(restart || (run && tick)));
endmodule

// File: rtl/pw_conn_fsm.sv
module pw_conn_fsm
  import pw_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      oam_en,
  input  logic      hit,
  input  logic      link_lost,
  output pw_state_e state_q,
  output logic      restart,
  output logic      run
);
  pw_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = PW_IDLE;
    end else if (!oam_en) begin
      state_d = PW_CONN;
    end else begin
      unique case (state_q)
        PW_IDLE: state_d = PW_REQ;
        PW_REQ:  state_d = (hit && !link_lost) ? PW_CONN : PW_REQ;
        PW_CONN: state_d = link_lost ? PW_REQ : PW_CONN;
        default: state_d = PW_IDLE;
      endcase
    end
  end

  assign restart = (state_d == PW_REQ) && ((state_q != PW_REQ) || link_lost);
  assign run     = (state_q == PW_REQ) && (state_d == PW_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PW_IDLE;
    else        state_q <= state_d;
  end

  // R9: disabling always returns to idle
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == PW_IDLE);
  // R5: a valid reply while requesting connects
  a_r5_hit_connects: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_REQ && hit && !link_lost && en && oam_en) |=> state_q == PW_CONN);
endmodule

// File: rtl/pw_handshake_ctrl.sv
module pw_handshake_ctrl
  import pw_hs_pkg::*;
#(
  parameter int BID_W        = 8,
  parameter int LBL_W        = 20,
  parameter int SZ_W         = 12,
  parameter int PERIOD_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             oam_en,
  input  logic             tick,
  input  logic             link_lost,
  input  logic             rep_valid,
  output logic             rep_ready,
  input  logic [BID_W-1:0] rep_bid,
  input  logic [LBL_W-1:0] rep_lbl,
  input  logic [SZ_W-1:0]  rep_size,
  input  logic [BID_W-1:0] cfg_bid,
  input  logic [LBL_W-1:0] cfg_lbl,
  input  logic [SZ_W-1:0]  cfg_size,
  output logic             req_strobe,
  output logic             traffic_en,
  output logic [1:0]       state_o
);
  pw_state_e st;
  logic      hit, restart, run;

  pw_reply_match #(.BID_W(BID_W), .LBL_W(LBL_W), .SZ_W(SZ_W)) u_match (
    .rep_valid(rep_valid), .rep_bid(rep_bid), .rep_lbl(rep_lbl), .rep_size(rep_size),
    .cfg_bid(cfg_bid), .cfg_lbl(cfg_lbl), .cfg_size(cfg_size), .hit(hit)
  );

  pw_conn_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .oam_en(oam_en), .hit(hit),
    .link_lost(link_lost), .state_q(st), .restart(restart), .run(run)
  );

  pw_req_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .tick(tick),
    .req_strobe(req_strobe)
  );

  assign rep_ready  = 1'b1;
  assign traffic_en = (st == PW_CONN);
  assign state_o    = st;

  // R2: with checking on, the gate opens only on a matching reply
  a_r2_gate_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(traffic_en) && $past(oam_en)) |->
      $past(rep_valid && rep_bid == cfg_bid && rep_lbl == cfg_lbl && rep_size == cfg_size));
  // R5: no requests while the gate is open
  a_r5_quiet_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    traffic_en |-> !req_strobe);
  // R6: a loss while connected triggers a request
  a_r6_loss_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (traffic_en && link_lost && oam_en && en) |=> (req_strobe && !traffic_en));
  // R8: requests only when checking is on and the bundle enabled
  a_r8_no_req_without_oam: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(oam_en && en));
endmodule

// File: tb/tb_pw_handshake_ctrl.sv
module tb_pw_handshake_ctrl;
  localparam int CLK_P  = 10;
  localparam int PER    = 4;
  localparam int BID_W  = 8;
  localparam int LBL_W  = 20;
  localparam int SZ_W   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, oam_en = 0, tick = 0, link_lost = 0, rep_valid = 0;
  logic rep_ready, req_strobe, traffic_en;
  logic [1:0] state_o;
  logic [BID_W-1:0] rep_bid = '0, cfg_bid = 8'h2A;
  logic [LBL_W-1:0] rep_lbl = '0, cfg_lbl = 20'h12345;
  logic [SZ_W-1:0]  rep_size = '0, cfg_size = 12'd320;

  int cyc = 0, total = 0, bad = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pw_handshake_ctrl #(.BID_W(BID_W), .LBL_W(LBL_W), .SZ_W(SZ_W), .PERIOD_TICKS(PER)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .oam_en(oam_en), .tick(tick), .link_lost(link_lost),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_bid(rep_bid), .rep_lbl(rep_lbl),
    .rep_size(rep_size), .cfg_bid(cfg_bid), .cfg_lbl(cfg_lbl), .cfg_size(cfg_size),
    .req_strobe(req_strobe), .traffic_en(traffic_en), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_st(input string req, input int st, input int gate);
    chk(state_o == st[1:0], req, state_o, st);
    chk(traffic_en == gate[0], req, traffic_en, gate);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Driver: one tick pulse; pushes the cycle a request must appear in.
  task automatic pulse_tick(input bit want_req);
    if (want_req) exp_q.push_back(cyc + 1);
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic send_reply(input logic [BID_W-1:0] b, input logic [LBL_W-1:0] l,
                            input logic [SZ_W-1:0] s);
    rep_bid = b; rep_lbl = l; rep_size = s; rep_valid = 1'b1;
    step();
    rep_valid = 1'b0;
  endtask

  // Monitor: every request pulse must match the next expected cycle (R4).
  always @(negedge clk) begin
    if (rst_n && req_strobe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected request", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R4 request cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk_st("R1 in reset", 0, 0);
    rst_n = 1'b1;
    step(); step();
    chk_st("R1 after reset", 0, 0);
    chk(rep_ready == 1'b1, "R3 ready high", rep_ready, 1);

    // R2: first request one cycle after enable
    oam_en = 1'b1;
    exp_q.push_back(cyc + 1);
    en = 1'b1;
    step();
    chk_st("R2 requesting", 1, 0);

    // R4: period of PER ticks, ticks spaced unevenly
    pulse_tick(0); step(); pulse_tick(0); pulse_tick(0); step(); step();
    pulse_tick(1);

    // R3/R7: one bad field at a time; timer keeps running
    pulse_tick(0); pulse_tick(0);
    send_reply(cfg_bid ^ 8'h01, cfg_lbl, cfg_size);
    chk_st("R3 bad bid ignored", 1, 0);
    pulse_tick(0);
    send_reply(cfg_bid, cfg_lbl ^ 20'h80000, cfg_size);
    chk_st("R3 bad label ignored", 1, 0);
    send_reply(cfg_bid, cfg_lbl, cfg_size + 12'd1);
    chk_st("R3 bad size ignored", 1, 0);
    pulse_tick(1);  // R7: fourth tick since last request still fires

    // R5: good reply connects, requests stop
    pulse_tick(0);
    send_reply(cfg_bid, cfg_lbl, cfg_size);
    chk_st("R5 connected", 2, 1);
    for (int i = 0; i < 6; i++) pulse_tick(0);
    send_reply(cfg_bid ^ 8'hFF, cfg_lbl, cfg_size);
    chk_st("R5 reply while connected", 2, 1);

    // R6: loss reopens the handshake
    exp_q.push_back(cyc + 1);
    link_lost = 1'b1;
    step();
    link_lost = 1'b0;
    chk_st("R6 loss", 1, 0);
    pulse_tick(0); pulse_tick(0); pulse_tick(0); pulse_tick(1);

    // R6: loss outranks a good reply and restarts the period
    pulse_tick(0); pulse_tick(0);
    exp_q.push_back(cyc + 1);
    link_lost = 1'b1;
    rep_bid = cfg_bid; rep_lbl = cfg_lbl; rep_size = cfg_size; rep_valid = 1'b1;
    step();
    link_lost = 1'b0; rep_valid = 1'b0;
    chk_st("R6 loss beats reply", 1, 0);
    pulse_tick(0); pulse_tick(0); pulse_tick(0);

    // R5: good reply on the period's last tick: no request
    tick = 1'b1;
    rep_bid = cfg_bid; rep_lbl = cfg_lbl; rep_size = cfg_size; rep_valid = 1'b1;
    step();
    tick = 1'b0; rep_valid = 1'b0;
    chk_st("R5 reply on last tick", 2, 1);
    step();

    // R9: disable
    en = 1'b0;
    step();
    chk_st("R9 disabled", 0, 0);
    for (int i = 0; i < 5; i++) pulse_tick(0);
    chk_st("R9 stays idle", 0, 0);

    // R8: checking off
    oam_en = 1'b0;
    en = 1'b1;
    step();
    chk_st("R8 immediate gate", 2, 1);
    link_lost = 1'b1;
    step();
    link_lost = 1'b0;
    chk_st("R8 loss no effect", 2, 1);
    for (int i = 0; i < 5; i++) pulse_tick(0);
    chk_st("R8 still open", 2, 1);

    // R2: re-enable with checking on
    en = 1'b0;
    step();
    oam_en = 1'b1;
    exp_q.push_back(cyc + 1);
    en = 1'b1;
    step();
    chk_st("R2 restart", 1, 0);
    step(); step();

    chk(exp_q.size() == 0, "R4 missing requests", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule